// File: doc/BRIEF.md
# Timestamped Invalidate Steering Unit

This unit sits at one processor node of a speculative shared-memory system. The node keeps a local virtual time counter, which it advances on its own. Each incoming invalidate carries an address and the timestamp of the writer. The unit compares that timestamp with local time and acts on the result:

- If the stamp equals local time, the invalidate is applied at once.
- If the stamp is older than local time, the unit asks the node to roll back to the stamp.
- If the stamp is newer than local time, the invalidate is parked in a small time-sorted queue. It is released when local time catches up.

The node's own write invalidates leave the unit stamped with the current local time. State restoration and message transport are handled outside the unit.

Top module: `tsinv_arbiter`

## Requirements
- R1: After reset, `lvt` is 0, `rb_valid` and `app_valid` are low, and `in_ready` is high.
- R2: Each cycle that `tick` is high and no rollback is pending, `lvt` increases by one at the next edge.
- R3: `wr_out_valid` and `wr_out_addr` follow `wr_req` and `wr_addr` in the same cycle, and `wr_out_ts` equals the current `lvt`.
- R4: An accepted invalidate whose timestamp equals `lvt` gives `app_valid` high for one cycle after the accepting edge, with its address on `app_addr`. No rollback is raised.
- R5: An accepted invalidate whose timestamp is below `lvt` raises `rb_valid` after the accepting edge, with `rb_ts` and `rb_addr` taken from the message. Nothing is applied.
- R6: While `rb_valid` is high and `rb_ack` is low, `rb_ts` and `rb_addr` hold, `lvt` does not change even when `tick` is high, and `in_ready` stays low.
- R7: An edge with `rb_valid` and `rb_ack` both high clears `rb_valid` and loads `lvt` with `rb_ts`.
- R8: An accepted invalidate whose timestamp is above `lvt` is held. It is applied (`app_valid`) in the cycle after the first edge at which `lvt` reaches its stamp.
- R9: Held invalidates leave in ascending timestamp order. Entries with equal stamps leave in the order they arrived. At most one invalidate is applied per cycle, and `in_ready` is low while a release is due.
- R10: When `DEPTH` entries are held, `in_ready` is low. A message offered meanwhile is kept by its sender and accepted later, never dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Advance local time by one |
| in_valid | input | 1 | Incoming invalidate offered |
| in_ready | output | 1 | Incoming invalidate can be taken |
| in_addr | input | AW | Incoming invalidate address |
| in_ts | input | TW | Incoming invalidate timestamp |
| app_valid | output | 1 | Invalidate applied this cycle |
| app_addr | output | AW | Address of applied invalidate |
| rb_valid | output | 1 | Rollback request pending |
| rb_ack | input | 1 | Rollback request accepted |
| rb_ts | output | TW | Rollback target time |
| rb_addr | output | AW | Address that caused the rollback |
| wr_req | input | 1 | Local write issues an invalidate |
| wr_addr | input | AW | Local write address |
| wr_out_valid | output | 1 | Outgoing invalidate valid |
| wr_out_addr | output | AW | Outgoing invalidate address |
| wr_out_ts | output | TW | Outgoing invalidate timestamp |
| lvt | output | TW | Current local virtual time |

## Verification
The assertions assume that local time never wraps. They also assume that `rb_ack` is raised only while a request is pending, and that the sender holds a message until `in_ready` takes it. The stimulus keeps every stamp far below the counter limit. It pulses `rb_ack` only after it has observed `rb_valid`, and it drives each message through a task that waits for `in_ready`. The stamps in the release test are chosen above local time throughout, so that no parked message turns into a rollback while the test runs.

// File: rtl/tsinv_arbiter.sv
module tsinv_arbiter #(
  parameter int TW    = 16,
  parameter int AW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [TW-1:0] in_ts,
  output logic          app_valid,
  output logic [AW-1:0] app_addr,
  output logic          rb_valid,
  input  logic          rb_ack,
  output logic [TW-1:0] rb_ts,
  output logic [AW-1:0] rb_addr,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  output logic          wr_out_valid,
  output logic [AW-1:0] wr_out_addr,
  output logic [TW-1:0] wr_out_ts,
  output logic [TW-1:0] lvt
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [TW-1:0] lvt_q;
  logic [CW-1:0] cnt;
  logic [TW-1:0] q_ts [DEPTH];
  logic [AW-1:0] q_ad [DEPTH];
  logic [CW-1:0] pos;

  wire due   = (cnt != '0) && (q_ts[0] <= lvt_q);
  assign in_ready = !rb_valid && (cnt != CW'(DEPTH)) && !due;
  wire take  = in_valid && in_ready;
  wire early = in_ts <  lvt_q;
  wire same  = in_ts == lvt_q;
  wire push  = take && (in_ts > lvt_q);

  assign lvt          = lvt_q;
  assign wr_out_valid = wr_req;
  assign wr_out_addr  = wr_addr;
  assign wr_out_ts    = lvt_q;

  always_comb begin
    pos = '0;
    for (int i = 0; i < DEPTH; i++)
      if (CW'(i) < cnt && q_ts[i] <= in_ts) pos = pos + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvt_q     <= '0;
      cnt       <= '0;
      rb_valid  <= 1'b0;
      rb_ts     <= '0;
      rb_addr   <= '0;
      app_valid <= 1'b0;
      app_addr  <= '0;
    end else begin
      if (rb_valid && rb_ack)      lvt_q <= rb_ts;
      else if (tick && !rb_valid)  lvt_q <= lvt_q + 1'b1;

      if (take && early) begin
        rb_valid <= 1'b1;
        rb_ts    <= in_ts;
        rb_addr  <= in_addr;
      end else if (rb_ack) begin
        rb_valid <= 1'b0;
      end

      app_valid <= (take && same) || due;
      app_addr  <= due ? q_ad[0] : in_addr;

      if (due)       cnt <= cnt - 1'b1;
      else if (push) cnt <= cnt + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (due) begin
        if (g < DEPTH - 1) begin
          q_ts[g] <= q_ts[(g < DEPTH - 1) ? g + 1 : g];
          q_ad[g] <= q_ad[(g < DEPTH - 1) ? g + 1 : g];
        end
      end else if (push) begin
        if (CW'(g) == pos) begin
          q_ts[g] <= in_ts;
          q_ad[g] <= in_addr;
        end else if (CW'(g) > pos) begin
          q_ts[g] <= q_ts[(g > 0) ? g - 1 : 0];
          q_ad[g] <= q_ad[(g > 0) ? g - 1 : 0];
        end
      end
    end
    if (g < DEPTH - 1) begin : g_ord
      a_r9_sorted: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt > CW'(g + 1)) |-> (q_ts[g] <= q_ts[g + 1]));
    end
  end

  a_r2_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rb_valid) |=> (lvt == $past(lvt) + 1'b1));
  a_r4_same: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_ts == lvt) |=> (app_valid && app_addr == $past(in_addr) && !rb_valid));
  a_r5_early: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_ts < lvt) |=> (rb_valid && rb_ts == $past(in_ts) && rb_addr == $past(in_addr)));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && !rb_ack) |=> (rb_valid && $stable(rb_ts) && $stable(rb_addr) && $stable(lvt)));
  a_r6_noaccept: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> !in_ready);
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && rb_ack) |=> (!rb_valid && lvt == $past(rb_ts)));
  a_r10_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH)) |-> !in_ready);
endmodule

// File: tb/tsinv_arbiter_tb.sv
module tsinv_arbiter_tb;
  localparam int TW = 16, AW = 16, DEPTH = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0, tick = 0, in_valid = 0, rb_ack = 0, wr_req = 0;
  logic [AW-1:0] in_addr = '0, wr_addr = '0;
  logic [TW-1:0] in_ts = '0;
  logic in_ready, app_valid, rb_valid, wr_out_valid;
  logic [AW-1:0] app_addr, rb_addr, wr_out_addr;
  logic [TW-1:0] rb_ts, wr_out_ts, lvt;

  int checks = 0, fails = 0;
  logic [AW-1:0] expq[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsinv_arbiter #(.TW(TW), .AW(AW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_ts(in_ts), .app_valid(app_valid), .app_addr(app_addr),
    .rb_valid(rb_valid), .rb_ack(rb_ack), .rb_ts(rb_ts), .rb_addr(rb_addr),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_out_valid(wr_out_valid),
    .wr_out_addr(wr_out_addr), .wr_out_ts(wr_out_ts), .lvt(lvt));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [AW-1:0] a, logic [TW-1:0] t);
    in_valid = 1; in_addr = a; in_ts = t;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  always @(negedge clk) if (rst_n && app_valid) begin
    if (expq.size() == 0) chk("R9 unexpected apply", app_addr, 32'hffff);
    else chk("R9 apply order", app_addr, expq.pop_front());
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 lvt", lvt, 0);
    chk("R1 ready", in_ready, 1);
    chk("R1 rb_valid", rb_valid, 0);
    chk("R1 app_valid", app_valid, 0);

    tick = 1; repeat (5) @(negedge clk); tick = 0;
    chk("R2 lvt after 5 ticks", lvt, 5);

    wr_req = 1; wr_addr = 16'h00ab; #1;
    chk("R3 out valid", wr_out_valid, 1);
    chk("R3 out addr", wr_out_addr, 16'h00ab);
    chk("R3 out ts", wr_out_ts, 5);
    wr_req = 0;

    expq.push_back(16'h00a1);
    send(16'h00a1, 5);
    chk("R4 applied next cycle", app_valid, 1);
    chk("R4 no rollback", rb_valid, 0);
    @(negedge clk);

    send(16'h00b0, 8); send(16'h00c0, 7); send(16'h00d0, 8); send(16'h00e0, 9);
    chk("R10 ready low when full", in_ready, 0);
    chk("R8 nothing applied early", app_valid, 0);
    expq.push_back(16'h00c0); expq.push_back(16'h00b0); expq.push_back(16'h00d0);
    expq.push_back(16'h00e0); expq.push_back(16'h00f0);
    fork
      send(16'h00f0, 20);
      begin tick = 1; repeat (16) @(negedge clk); tick = 0; end
    join
    repeat (3) @(negedge clk);
    chk("R2 lvt after 16 ticks", lvt, 21);
    chk("R9 R10 all released", expq.size(), 0);

    send(16'h0071, 23);
    tick = 1; @(negedge clk);
    chk("R8 held before stamp", app_valid, 0);
    @(negedge clk); tick = 0;
    chk("R8 held at reach edge", app_valid, 0);
    chk("R8 lvt reached", lvt, 23);
    expq.push_back(16'h0071);
    @(negedge clk);
    chk("R8 applied after reach", app_valid, 1);
    @(negedge clk);

    send(16'h0055, 20);
    chk("R5 rb_valid", rb_valid, 1);
    chk("R5 rb_ts", rb_ts, 20);
    chk("R5 rb_addr", rb_addr, 16'h0055);
    chk("R5 no apply", app_valid, 0);
    tick = 1; repeat (3) @(negedge clk); tick = 0;
    chk("R6 lvt frozen", lvt, 23);
    chk("R6 rb held", rb_valid, 1);
    chk("R6 rb_ts held", rb_ts, 20);
    chk("R6 ready low", in_ready, 0);
    rb_ack = 1; @(negedge clk); rb_ack = 0;
    chk("R7 rb cleared", rb_valid, 0);
    chk("R7 lvt loaded", lvt, 20);
    chk("R7 ready again", in_ready, 1);
    repeat (2) @(negedge clk);
    chk("R9 no leftover", expq.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule